// File: doc/BRIEF.md
# Double-Buffered Colour Matrix Converter

This block converts a stream of three-channel pixels (RGB or YCbCr) with a 3x4 affine matrix. It accepts one pixel per cycle when `pix_valid` is high. Each output channel is a weighted sum of the three input channels plus an offset. The sum is rounded and then clamped to the unsigned pixel range. A bypass setting sends pixels through untouched.

Two coefficient banks sit behind a small register port. Software reads the status word to learn which bank is live. It then fills the other bank and writes the control word to request that bank. The request waits as a pending setting and becomes live only on a `frame_start` pulse. When that happens, the selected bank is copied into a working set that the datapath uses for the whole frame. No frame therefore mixes two coefficient sets. Optional input centering removes the mid-level from both chroma channels, so that colour-difference inputs are signed before the multiply.

Top module: `csc_dbuf_matrix`

## Requirements
- R1: Each output channel r equals floor((sum over c of K[r][c]*x[c] + K[r][3]*2^13 + 2^12) / 2^13). K holds signed 16-bit coefficients with 13 fraction bits, so 0x2000 is unity gain. The offset K[r][3] is in pixel LSBs. Channel c occupies pix bits [c*PIX_W +: PIX_W].
- R2: The output appears with `pix_out_valid` exactly two clock edges after the input was accepted. No output is produced without an accepted input.
- R3: A live mode of 0 passes pixels through unchanged. Live mode values 1, 2, 3, 6 and 7 behave the same way.
- R4: Live mode 4 converts with bank A. Live mode 5 converts with bank B.
- R5: Register map: addresses 0..11 hold bank A coefficient K[r][c] at r*4+c, where column 3 is the offset. Addresses 16..27 hold bank B in the same layout. Address 31 is control: bits [2:0] are the mode and bit 8 is chroma centering. A write to address 31 changes only the pending setting. Writes to any other address are ignored.
- R6: On `frame_start` the pending setting becomes live. A pixel accepted in the same cycle as `frame_start` already uses the new setting. Pixels accepted earlier, including those still in flight, keep the old one.
- R7: Reading address 31 returns the live mode in [2:0], the pending mode in [6:4], live centering in bit 8 and pending centering in bit 9. All other bits read 0.
- R8: Reading a coefficient address returns the value last written there. Unmapped addresses other than 31 read 0.
- R9: At `frame_start` the bank selected by the pending mode is captured. A later write to that bank has no effect on the output until the next `frame_start`.
- R10: With centering live and mode 4 or 5, 2^(PIX_W-1) is subtracted from channels 1 and 2 before the multiply. Channel 0 is used as is.
- R11: After reset both banks are 0, the live and pending modes are 0 with centering off, and `pix_out_valid` is low.
- R12: A result below 0 is output as 0. A result above 2^PIX_W-1 is output as 2^PIX_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse marking a frame boundary |
| pix_valid | input | 1 | Input pixel valid |
| pix_in | input | 3*PIX_W | Input pixel, channel 0 in the low bits |
| pix_out_valid | output | 1 | Output pixel valid |
| pix_out | output | 3*PIX_W | Converted pixel, channel r in slice r |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr`, combinational |

## Verification
The checks assume that `pix_valid` is low while reset is asserted. They also assume that `frame_start` is a single-cycle pulse that never coincides with a coefficient write, so the bank captured at a boundary is the one stored before that cycle. The stimulus keeps every register write on a cycle of its own, apart from pixel traffic and frame pulses. It issues each boundary together with the first pixel of a sweep, or inside a back-to-back stream to exercise the in-flight case. The expected pixels are produced by an arithmetic model of the matrix and are compared as the outputs emerge.

// File: rtl/csc_pkg.sv
package csc_pkg;
    localparam int COEF_W      = 16;
    localparam int FRAC_W      = 13;
    localparam int N_ROW       = 3;
    localparam int N_COL       = 4;
    localparam int N_COEF      = N_ROW * N_COL;
    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 16;
    localparam int MODE_W      = 3;
    localparam int BANK_A_BASE = 0;
    localparam int BANK_B_BASE = 16;
    localparam int CTRL_ADDR   = 31;
    localparam int CENTER_BIT  = 8;

    localparam logic [MODE_W-1:0] MODE_BYPASS = 3'd0;
    localparam logic [MODE_W-1:0] MODE_BANK_A = 3'd4;
    localparam logic [MODE_W-1:0] MODE_BANK_B = 3'd5;

    typedef logic [COEF_W-1:0] coef_t;
    typedef coef_t [N_COEF-1:0] coef_set_t;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              center;
    } cfg_t;

    function automatic logic mode_converts(input logic [MODE_W-1:0] m);
        return (m == MODE_BANK_A) || (m == MODE_BANK_B);
    endfunction

    function automatic coef_set_t pick_bank(input logic [MODE_W-1:0] m,
                                            input coef_set_t a,
                                            input coef_set_t b,
                                            input coef_set_t keep);
        if (m == MODE_BANK_A) return a;
        if (m == MODE_BANK_B) return b;
        return keep;
    endfunction
endpackage

// File: rtl/csc_coef_banks.sv
module csc_coef_banks
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output coef_set_t         bank_a,
    output coef_set_t         bank_b,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_hit
);
    typedef struct packed {
        coef_set_t a;
        coef_set_t b;
    } banks_t;

    banks_t banks_d, banks_q;

    always_comb begin
        banks_d = banks_q;
        if (wr_en) begin
            for (int i = 0; i < N_COEF; i++) begin
                if (addr == ADDR_W'(BANK_A_BASE + i)) banks_d.a[i] = wdata;
                if (addr == ADDR_W'(BANK_B_BASE + i)) banks_d.b[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) banks_q <= '0;
        else        banks_q <= banks_d;
    end

    always_comb begin
        rd_data = '0;
        rd_hit  = 1'b0;
        for (int i = 0; i < N_COEF; i++) begin
            if (addr == ADDR_W'(BANK_A_BASE + i)) begin
                rd_data = banks_q.a[i];
                rd_hit  = 1'b1;
            end
            if (addr == ADDR_W'(BANK_B_BASE + i)) begin
                rd_data = banks_q.b[i];
                rd_hit  = 1'b1;
            end
        end
    end

    assign bank_a = banks_q.a;
    assign bank_b = banks_q.b;
endmodule

// File: rtl/csc_mode_ctrl.sv
module csc_mode_ctrl
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              center_wdata,
    input  logic              frame_start,
    input  coef_set_t         bank_a,
    input  coef_set_t         bank_b,
    output cfg_t              live_cfg,
    output cfg_t              pend_cfg,
    output coef_set_t         live_coefs,
    output logic              eff_bypass,
    output logic              eff_center,
    output coef_set_t         eff_coefs
);
    typedef struct packed {
        cfg_t      pend;
        cfg_t      live;
        coef_set_t work;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (ctrl_we) begin
            ctl_d.pend.mode   = mode_wdata;
            ctl_d.pend.center = center_wdata;
        end
        if (frame_start) begin
            ctl_d.live = ctl_q.pend;
            ctl_d.work = pick_bank(ctl_q.pend.mode, bank_a, bank_b, ctl_q.work);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // A pixel arriving with the boundary pulse already sees the new setting.
    always_comb begin
        if (frame_start) begin
            eff_bypass = !mode_converts(ctl_q.pend.mode);
            eff_center = ctl_q.pend.center;
            eff_coefs  = pick_bank(ctl_q.pend.mode, bank_a, bank_b, ctl_q.work);
        end else begin
            eff_bypass = !mode_converts(ctl_q.live.mode);
            eff_center = ctl_q.live.center;
            eff_coefs  = ctl_q.work;
        end
    end

    assign live_cfg   = ctl_q.live;
    assign pend_cfg   = ctl_q.pend;
    assign live_coefs = ctl_q.work;
endmodule

// File: rtl/csc_mac_pipe.sv
module csc_mac_pipe
    import csc_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_bypass,
    input  logic                   in_center,
    input  logic [N_ROW*PIX_W-1:0] in_pix,
    input  coef_set_t              in_coefs,
    output logic                   out_valid,
    output logic [N_ROW*PIX_W-1:0] out_pix
);
    localparam int N_IN     = N_COL - 1;
    localparam int PIX_BITS = N_ROW * PIX_W;
    localparam int X_W      = PIX_W + 1;
    localparam int PROD_W   = COEF_W + X_W;
    localparam int OFF_W    = COEF_W + FRAC_W;
    localparam int ACC_W    = ((PROD_W > OFF_W) ? PROD_W : OFF_W) + 3;
    localparam int HALF     = 1 << (PIX_W - 1);
    localparam int PIX_MAX  = (1 << PIX_W) - 1;
    localparam int RND      = 1 << (FRAC_W - 1);

    typedef struct packed {
        logic                                valid;
        logic                                bypass;
        logic [PIX_BITS-1:0]                 raw;
        logic [N_ROW*N_IN-1:0][PROD_W-1:0]   prod;
        logic [N_ROW-1:0][COEF_W-1:0]        off;
    } s1_t;

    typedef struct packed {
        logic                valid;
        logic [PIX_BITS-1:0] pix;
    } s2_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [X_W-1:0]    x_w    [N_IN];
    logic signed [PROD_W-1:0] prod_w [N_ROW*N_IN];
    logic [PIX_BITS-1:0]      row_cat;

    for (genvar c = 0; c < N_IN; c++) begin : g_in
        if (c == 0) begin : g_luma
            assign x_w[c] = $signed({1'b0, in_pix[c*PIX_W +: PIX_W]});
        end else begin : g_chroma
            assign x_w[c] = in_center
                ? ($signed({1'b0, in_pix[c*PIX_W +: PIX_W]}) - $signed(X_W'(HALF)))
                :  $signed({1'b0, in_pix[c*PIX_W +: PIX_W]});
        end
    end

    for (genvar r = 0; r < N_ROW; r++) begin : g_mul_row
        for (genvar c = 0; c < N_IN; c++) begin : g_mul_col
            assign prod_w[r*N_IN+c] = PROD_W'($signed(in_coefs[r*N_COL+c])) * PROD_W'(x_w[c]);
        end
    end

    for (genvar r = 0; r < N_ROW; r++) begin : g_sum_row
        logic signed [ACC_W-1:0] acc_v;
        logic signed [ACC_W-1:0] shf_v;
        logic [PIX_W-1:0]        sat_v;

        always_comb begin
            acc_v = ACC_W'(RND);
            for (int c = 0; c < N_IN; c++) begin
                acc_v = acc_v + ACC_W'($signed(pipe_q.s1.prod[r*N_IN+c]));
            end
            acc_v = acc_v + (ACC_W'($signed(pipe_q.s1.off[r])) <<< FRAC_W);
            shf_v = acc_v >>> FRAC_W;
            if (shf_v[ACC_W-1]) begin
                sat_v = '0;
            end else if (shf_v > $signed(ACC_W'(PIX_MAX))) begin
                sat_v = '1;
            end else begin
                sat_v = shf_v[PIX_W-1:0];
            end
        end

        assign row_cat[r*PIX_W +: PIX_W] = sat_v;
    end

    always_comb begin
        pipe_d = pipe_q;
        pipe_d.s1.valid  = in_valid;
        pipe_d.s1.bypass = in_bypass;
        pipe_d.s1.raw    = in_pix;
        for (int i = 0; i < N_ROW*N_IN; i++) begin
            pipe_d.s1.prod[i] = prod_w[i];
        end
        for (int r = 0; r < N_ROW; r++) begin
            pipe_d.s1.off[r] = in_coefs[r*N_COL + N_IN];
        end
        pipe_d.s2.valid = pipe_q.s1.valid;
        pipe_d.s2.pix   = pipe_q.s1.bypass ? pipe_q.s1.raw : row_cat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s2.valid;
    assign out_pix   = pipe_q.s2.pix;
endmodule

// File: rtl/csc_dbuf_matrix.sv
module csc_dbuf_matrix
    import csc_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic                   pix_valid,
    input  logic [N_ROW*PIX_W-1:0] pix_in,
    output logic                   pix_out_valid,
    output logic [N_ROW*PIX_W-1:0] pix_out,
    input  logic                   reg_we,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata
);
    coef_set_t         bank_a, bank_b, live_coefs, eff_coefs;
    cfg_t              live_cfg, pend_cfg;
    logic              eff_bypass, eff_center;
    logic [DATA_W-1:0] coef_rd;
    logic              coef_hit;
    logic              ctrl_sel;
    logic [MODE_W-1:0] live_mode, pend_mode;

    assign ctrl_sel  = (reg_addr == ADDR_W'(CTRL_ADDR));
    assign live_mode = live_cfg.mode;
    assign pend_mode = pend_cfg.mode;

    csc_coef_banks u_banks (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .bank_a  (bank_a),
        .bank_b  (bank_b),
        .rd_data (coef_rd),
        .rd_hit  (coef_hit)
    );

    csc_mode_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_we      (reg_we && ctrl_sel),
        .mode_wdata   (reg_wdata[MODE_W-1:0]),
        .center_wdata (reg_wdata[CENTER_BIT]),
        .frame_start  (frame_start),
        .bank_a       (bank_a),
        .bank_b       (bank_b),
        .live_cfg     (live_cfg),
        .pend_cfg     (pend_cfg),
        .live_coefs   (live_coefs),
        .eff_bypass   (eff_bypass),
        .eff_center   (eff_center),
        .eff_coefs    (eff_coefs)
    );

    csc_mac_pipe #(.PIX_W(PIX_W)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (pix_valid),
        .in_bypass (eff_bypass),
        .in_center (eff_center),
        .in_pix    (pix_in),
        .in_coefs  (eff_coefs),
        .out_valid (pix_out_valid),
        .out_pix   (pix_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (ctrl_sel) begin
            reg_rdata[MODE_W-1:0]         = live_cfg.mode;
            reg_rdata[4 +: MODE_W]        = pend_cfg.mode;
            reg_rdata[CENTER_BIT]         = live_cfg.center;
            reg_rdata[CENTER_BIT + 1]     = pend_cfg.center;
        end else if (coef_hit) begin
            reg_rdata = coef_rd;
        end
    end
endmodule

// File: rtl/csc_dbuf_chk.sv
module csc_dbuf_chk
    import csc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              pix_valid,
    input logic              pix_out_valid,
    input logic [MODE_W-1:0] live_mode,
    input logic [MODE_W-1:0] pend_mode,
    input coef_set_t         live_coefs
);
    // R2
    valid_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ##1 pix_out_valid);

    // R2
    valid_bwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out_valid |-> $past(pix_valid, 2));

    // R6
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(live_mode));

    // R6
    live_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (live_mode == $past(pend_mode)));

    // R9
    work_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(live_coefs));
endmodule

bind csc_dbuf_matrix csc_dbuf_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_start   (frame_start),
    .pix_valid     (pix_valid),
    .pix_out_valid (pix_out_valid),
    .live_mode     (live_mode),
    .pend_mode     (pend_mode),
    .live_coefs    (live_coefs)
);

// File: tb/tb_csc_dbuf_matrix.sv
module tb_csc_dbuf_matrix;
    localparam int CLK_PERIOD = 10;
    localparam int PW   = 10;
    localparam int PB   = 3 * PW;
    localparam int FR   = 13;
    localparam int HALF = 1 << (PW - 1);
    localparam int PMAX = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          pix_valid = 1'b0;
    logic [PB-1:0] pix_in = '0;
    logic          pix_out_valid;
    logic [PB-1:0] pix_out;
    logic          reg_we = 1'b0;
    logic [4:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [15:0] m_a [12];
    logic [15:0] m_b [12];
    logic [15:0] m_w [12];
    logic [2:0]  m_pend = 0, m_live = 0;
    bit          m_pc = 0, m_lc = 0;
    string       cur_tag = "R1";

    logic [PB-1:0] exp_q [$];
    string         tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    csc_dbuf_matrix #(.PIX_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pix_valid(pix_valid), .pix_in(pix_in),
        .pix_out_valid(pix_out_valid), .pix_out(pix_out),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [PB-1:0] model(input logic [PB-1:0] p);
        logic [PB-1:0] o;
        longint acc, x, y;
        if (m_live != 3'd4 && m_live != 3'd5) return p;
        for (int r = 0; r < 3; r++) begin
            acc = longint'(1) << (FR - 1);
            for (int c = 0; c < 3; c++) begin
                x = longint'(p[c*PW +: PW]);
                if (m_lc && c > 0) x = x - HALF;
                acc = acc + longint'($signed(m_w[r*4+c])) * x;
            end
            acc = acc + longint'($signed(m_w[r*4+3])) * (longint'(1) << FR);
            y = acc >>> FR;
            if (y < 0) y = 0;
            if (y > PMAX) y = PMAX;
            o[r*PW +: PW] = PW'(y);
        end
        return o;
    endfunction

    always @(negedge clk) begin
        if (rst_n && pix_out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 output without input", 64'(pix_out), 64'(0));
            end else begin
                logic [PB-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(pix_out == e, t, 64'(pix_out), 64'(e));
            end
        end
    end

    task automatic drive(input logic [PB-1:0] p, input bit v, input bit fs);
        @(negedge clk);
        reg_we = 0; pix_valid = v; pix_in = p; frame_start = fs;
        if (fs) begin
            m_live = m_pend; m_lc = m_pc;
            if (m_pend == 3'd4) m_w = m_a;
            else if (m_pend == 3'd5) m_w = m_b;
        end
        if (v) begin
            exp_q.push_back(model(p));
            tag_q.push_back(cur_tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, 0, 0);
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        pix_valid = 0; frame_start = 0;
        reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
        if (a < 12) m_a[a] = d;
        else if (a >= 16 && a < 28) m_b[a-16] = d;
        else if (a == 31) begin m_pend = d[2:0]; m_pc = d[8]; end
    endtask

    task automatic rd(input int a, input logic [15:0] e, input string tag);
        @(negedge clk);
        reg_we = 0; pix_valid = 0; frame_start = 0; reg_addr = 5'(a);
        #1;
        chk(reg_rdata == e, tag, 64'(reg_rdata), 64'(e));
    endtask

    function automatic logic [PW-1:0] gv(input int k, input int n);
        if (k == n - 1) return PW'(PMAX);
        return PW'(k * (PMAX / (n - 1)));
    endfunction

    task automatic sweep(input string tag, input int n);
        bit first = 1;
        cur_tag = tag;
        for (int a = 0; a < n; a++)
            for (int b = 0; b < n; b++)
                for (int c = 0; c < n; c++) begin
                    drive({gv(c, n), gv(b, n), gv(a, n)}, 1, first);
                    first = 0;
                end
        idle(3);
    endtask

    task automatic load(input int base, input logic [15:0] k [12]);
        for (int i = 0; i < 12; i++) wr(base + i, k[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 64'(0), 64'(1));
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] mx1 [12];
        logic [15:0] mxb [12];
        logic [15:0] myc [12];
        mx1 = '{16'h3000, 16'hF000, 16'h1000, 16'h0020,
                16'hE000, 16'h4000, 16'h0000, 16'hFFF0,
                16'h0800, 16'h0800, 16'h0800, 16'h0100};
        mxb = '{16'h1000, 16'h0000, 16'h0000, 16'h0040,
                16'h0000, 16'h1000, 16'hFC00, 16'h0000,
                16'h0000, 16'h0000, 16'h2000, 16'hFF80};
        myc = '{16'h2000, 16'h0000, 16'h2CDD, 16'h0000,
                16'h2000, 16'hF4FD, 16'hE926, 16'h0000,
                16'h2000, 16'h38B4, 16'h0000, 16'h0000};
        for (int i = 0; i < 12; i++) begin m_a[i] = 0; m_b[i] = 0; m_w[i] = 0; end

        repeat (3) @(negedge clk);
        // R11 reset state
        chk(pix_out_valid == 0, "R11 out valid after reset", 64'(pix_out_valid), 64'(0));
        rst_n = 1;
        rd(31, 16'h0000, "R11 status after reset");
        rd(0, 16'h0000, "R11 bank A cleared");
        rd(27, 16'h0000, "R11 bank B cleared");

        // R3 bypass
        sweep("R3 bypass passthrough", 8);

        // R5 R8 load bank A, pending only
        load(0, mx1);
        rd(0, 16'h3000, "R8 readback A0");
        rd(7, 16'hFFF0, "R8 readback A7");
        wr(31, 16'h0004);
        rd(31, 16'h0040, "R7 pending A, live bypass");
        cur_tag = "R6 no switch before boundary";
        drive({10'd5, 10'd600, 10'd100}, 1, 0);
        idle(3);

        // R1 R12 R4 bank A
        sweep("R1 R12 bank A matrix", 16);
        rd(31, 16'h0044, "R7 live A");

        // R9 write live bank, load B while A live
        load(16, mxb);
        wr(0, 16'h2000);
        cur_tag = "R9 live bank write ignored";
        drive({10'd200, 10'd300, 10'd400}, 1, 0);
        drive({10'd1023, 10'd0, 10'd1023}, 1, 0);
        idle(3);
        wr(31, 16'h0005);
        sweep("R4 bank B matrix", 12);
        rd(31, 16'h0055, "R7 live B");
        wr(31, 16'h0004);
        sweep("R9 modified A after reselect", 8);

        // R10 centering
        load(0, myc);
        wr(31, 16'h0104);
        rd(31, 16'h0244, "R7 pending centering");
        sweep("R10 chroma centering", 12);
        rd(31, 16'h0344, "R7 live centering");

        // R3 other encodings
        wr(31, 16'h0003);
        sweep("R3 mode 3 passthrough", 6);
        wr(31, 16'h0006);
        sweep("R3 mode 6 passthrough", 6);

        // R6 switch inside a stream, pipeline in flight
        wr(31, 16'h0005);
        cur_tag = "R6 switch mid stream";
        for (int i = 0; i < 40; i++)
            drive({PW'(i * 25), PW'(1000 - i * 7), PW'(i * 13)}, 1, (i == 0) || (i == 20));
        wr(31, 16'h0104);
        for (int i = 0; i < 40; i++)
            drive({PW'(i * 11), PW'(i * 19), PW'(900 - i * 3)}, 1, (i == 17));
        idle(3);

        // R5 unmapped addresses ignored
        wr(12, 16'h1234);
        wr(28, 16'h5678);
        rd(12, 16'h0000, "R8 unmapped read 12");
        rd(11, myc[11], "R5 A11 untouched");
        rd(16, mxb[0], "R5 B0 untouched");
        rd(31, 16'h0344, "R5 control untouched");
        sweep("R5 output unchanged after unmapped writes", 5);

        idle(4);
        chk(exp_q.size() == 0, "R2 all outputs delivered", 64'(exp_q.size()), 64'(0));
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule